// File: doc/BRIEF.md
# Double-Buffer Frame Layer Arbiter

This block decides which of two frame-buffer layers a display reader scans out. A capture writer fills the layers in turn: it moves to the other layer at every writer frame start. At every reader frame start the arbiter latches a choice of layer for the reader, and that choice holds until the next reader frame start. In two-layer mode the choice depends on how far the writer has got in its current layer. If the writer's vertical position is already past a programmable threshold, the reader can safely follow it into the same layer, because a read pointer that starts at the top cannot catch a writer that is that far ahead. If the writer is not yet past the threshold, the reader gets the other layer, the one not being written.

Both the writer's line address and the threshold carry the same start-line offset, so they are compared directly. In frame mode the top threshold bit names a field, and the position compared is the pair made of the field and the line. In field mode only the line is compared. A status word reports three values: the layer being written, the layer written before it, and the layer on display. When the output runs faster than the input, the reader gets the same layer for several output frames in a row.

Top module: `flb_layer_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `rd_layer` is 0 and every bit of `status` is 0.
- R2: In two-layer mode (`cfg_single_layer`=0), each `wr_frame_start` pulse flips the write layer between 0 and 1. At the same edge the previous-write field takes the write layer held before that edge. Both changes are visible in `status` on the following cycle.
- R3: In single-layer mode (`cfg_single_layer`=1), a `wr_frame_start` keeps the write layer unchanged, though the previous-write field is still loaded with it. A `rd_frame_start` gives the reader the write layer whatever the threshold and line values are.
- R4: In two-layer mode, when the writer position is strictly greater than the threshold at a `rd_frame_start`, the reader is given the current write layer.
- R5: In two-layer mode, when the writer position is less than or equal to the threshold at a `rd_frame_start`, the reader is given the other layer (the inverse of the current write layer).
- R6: In field mode (`cfg_frame_mode`=0), the position is `wr_line` alone, the threshold is `cfg_threshold[13:0]`, and `cfg_threshold[14]` has no effect.
- R7: In frame mode (`cfg_frame_mode`=1), the position {`wr_field`, `wr_line`} is compared with {`cfg_threshold[14]`, `cfg_threshold[13:0]`} as one unsigned value. Every odd-field line (field=1) therefore ranks above every even-field line (field=0).
- R8: `rd_layer` changes only on the cycle after a `rd_frame_start` and otherwise stays at its value. Reader starts with no writer start in between can therefore show one layer repeatedly.
- R9: `status` bits [3:0] hold the current write layer, bits [7:4] hold the previous write layer and bits [15:8] hold the displayed layer, each zero-extended.
- R10: When `wr_frame_start` and `rd_frame_start` arrive on the same edge, the reader decision uses the write layer from before that edge's toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_frame_start | input | 1 | One-cycle pulse: the writer begins a new input frame or field |
| rd_frame_start | input | 1 | One-cycle pulse: the reader begins a new output frame |
| wr_line | input | 14 | Writer vertical line address, including the start-line offset |
| wr_field | input | 1 | Writer field: 0 even, 1 odd |
| cfg_threshold | input | 15 | Bit 14 is the threshold field, used in frame mode. Bits 13:0 are the threshold line. |
| cfg_single_layer | input | 1 | 1 selects single-layer mode, 0 selects two-layer mode |
| cfg_frame_mode | input | 1 | 1 compares the field together with the line, 0 compares the line only |
| rd_layer | output | 1 | Layer the reader displays for the current output frame |
| status | output | 16 | Status word: current write layer, previous write layer, displayed layer |

## Verification
The assertions assume that both frame-start inputs are single-cycle pulses sampled on the clock, and that the configuration and line inputs are valid at every edge where a pulse is high. They make no assumption about how the two pulses are spaced or how they overlap. The stimulus drives every input on the falling clock edge. It raises each pulse at random with a moderate probability, so that overlapping pulses and long gaps both occur. It places the line close to the threshold line, so that the equal case and the cases one line away are reached often. Directed steps add the exact-equality case, a field-mode run with threshold bit 14 set, a frame-mode case that crosses fields, and simultaneous pulses.

// File: rtl/flb_pkg.sv
// Package: shared widths and the status-word layout of the frame layer arbiter.
// Assumes two physical layers, so a layer identifier is one bit internally.
package flb_pkg;

    // Width of each status field
    localparam int CUR_ID_W  = 4;
    localparam int PREV_ID_W = 4;
    localparam int DISP_ID_W = 8;
    localparam int STATUS_W  = CUR_ID_W + PREV_ID_W + DISP_ID_W;

    // Bit positions inside the status word
    localparam int CUR_LSB  = 0;
    localparam int PREV_LSB = CUR_LSB + CUR_ID_W;
    localparam int DISP_LSB = PREV_LSB + PREV_ID_W;

    typedef logic layer_t;

    // Reader choice: follow the writer or take the idle layer
    typedef enum logic {
        PICK_IDLE   = 1'b0,
        PICK_FOLLOW = 1'b1
    } pick_e;

endpackage

// File: rtl/flb_write_track.sv
// Module: tracks the layer the writer is filling and the layer it filled before.
// Assumes wr_frame_start is a one-cycle pulse. In single-layer mode the layer
// does not move, but the previous-layer record is still refreshed.
module flb_write_track
    import flb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_frame_start,
    input  logic   single_layer,
    output layer_t cur_layer,
    output layer_t prev_layer
);

    layer_t next_layer;

    // Pick the layer for the next input frame
    always_comb begin
        if (single_layer) begin
            next_layer = cur_layer;
        end else begin
            next_layer = ~cur_layer;
        end
    end

    // Advance the write layer and its history at each writer frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_layer  <= 1'b0;
            prev_layer <= 1'b0;
        end else if (wr_frame_start) begin
            prev_layer <= cur_layer;
            cur_layer  <= next_layer;
        end
    end

endmodule

// File: rtl/flb_pos_compare.sv
// Module: decides whether the writer has passed the threshold.
// Assumes the line and the threshold carry the same start-line offset.
// In frame mode the field bit is the most significant part of the value.
module flb_pos_compare #(
    parameter int LINE_W = 14
) (
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_field,
    input  logic [LINE_W:0]   threshold,
    input  logic              frame_mode,
    output logic              passed
);

    localparam int POS_W = LINE_W + 1;

    logic [POS_W-1:0] pos_val;
    logic [POS_W-1:0] thr_val;

    // Build the ordered position and threshold values for the active mode
    always_comb begin
        if (frame_mode) begin
            pos_val = {wr_field, wr_line};
            thr_val = threshold;
        end else begin
            pos_val = {1'b0, wr_line};
            thr_val = {1'b0, threshold[LINE_W-1:0]};
        end
    end

    // Strictly beyond the threshold counts as passed
    always_comb begin
        passed = (pos_val > thr_val);
    end

endmodule

// File: rtl/flb_read_select.sv
// Module: latches the reader's layer at each reader frame start.
// Assumes rd_frame_start is a one-cycle pulse. The decision uses the write
// layer as registered before the edge, so a writer toggle on the same edge
// does not affect it.
module flb_read_select
    import flb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_frame_start,
    input  logic   single_layer,
    input  logic   passed,
    input  layer_t cur_layer,
    output layer_t rd_layer
);

    pick_e  pick;
    layer_t chosen;

    // Follow the writer in single-layer mode or once it is past the threshold
    always_comb begin
        if (single_layer || passed) begin
            pick = PICK_FOLLOW;
        end else begin
            pick = PICK_IDLE;
        end
    end

    // Translate the pick into a layer number
    always_comb begin
        case (pick)
            PICK_FOLLOW: chosen = cur_layer;
            default:     chosen = ~cur_layer;
        endcase
    end

    // Hold the choice for the whole output frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_layer <= 1'b0;
        end else if (rd_frame_start) begin
            rd_layer <= chosen;
        end
    end

endmodule

// File: rtl/flb_layer_arbiter.sv
// Module: top of the double-buffer frame layer arbiter. It chooses the layer
// the reader displays from the writer's layer and line position, and reports
// the layers in a status word.
// Assumes both frame-start inputs are synchronous one-cycle pulses.
module flb_layer_arbiter
    import flb_pkg::*;
#(
    parameter int LINE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_frame_start,
    input  logic                rd_frame_start,
    input  logic [LINE_W-1:0]   wr_line,
    input  logic                wr_field,
    input  logic [LINE_W:0]     cfg_threshold,
    input  logic                cfg_single_layer,
    input  logic                cfg_frame_mode,
    output logic                rd_layer,
    output logic [STATUS_W-1:0] status
);

    layer_t cur_layer;
    layer_t prev_layer;
    layer_t rd_layer_q;
    logic   passed;

    flb_write_track u_wtrack (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_frame_start (wr_frame_start),
        .single_layer   (cfg_single_layer),
        .cur_layer      (cur_layer),
        .prev_layer     (prev_layer)
    );

    flb_pos_compare #(.LINE_W(LINE_W)) u_cmp (
        .wr_line    (wr_line),
        .wr_field   (wr_field),
        .threshold  (cfg_threshold),
        .frame_mode (cfg_frame_mode),
        .passed     (passed)
    );

    flb_read_select u_rsel (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_frame_start (rd_frame_start),
        .single_layer   (cfg_single_layer),
        .passed         (passed),
        .cur_layer      (cur_layer),
        .rd_layer       (rd_layer_q)
    );

    // Drive the reader layer and pack the zero-extended status fields
    always_comb begin
        rd_layer = rd_layer_q;
        status   = '0;
        status[CUR_LSB  +: CUR_ID_W]  = {{(CUR_ID_W-1){1'b0}},  cur_layer};
        status[PREV_LSB +: PREV_ID_W] = {{(PREV_ID_W-1){1'b0}}, prev_layer};
        status[DISP_LSB +: DISP_ID_W] = {{(DISP_ID_W-1){1'b0}}, rd_layer_q};
    end

endmodule

// File: rtl/flb_layer_arbiter_chk.sv
// Module: assertion checker for flb_layer_arbiter. It observes the ports only
// and is attached to the top module with bind.
module flb_layer_arbiter_chk
    import flb_pkg::*;
#(
    parameter int LINE_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_frame_start,
    input logic                rd_frame_start,
    input logic [LINE_W-1:0]   wr_line,
    input logic                wr_field,
    input logic [LINE_W:0]     cfg_threshold,
    input logic                cfg_single_layer,
    input logic                cfg_frame_mode,
    input logic                rd_layer,
    input logic [STATUS_W-1:0] status
);

    logic cur_w;
    logic prev_w;
    logic beyond;

    // Observed write layers and an independent threshold test
    always_comb begin
        cur_w  = status[CUR_LSB];
        prev_w = status[PREV_LSB];
        if (cfg_frame_mode) begin
            beyond = {wr_field, wr_line} > cfg_threshold;
        end else begin
            beyond = wr_line > cfg_threshold[LINE_W-1:0];
        end
    end

    // R2: two-layer writer start flips the write layer
    p_wr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_start && !cfg_single_layer) |=> (cur_w != $past(cur_w)));

    // R2: the previous-write field takes the layer from before the start
    p_prev_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_frame_start |=> (prev_w == $past(cur_w)));

    // R3: single-layer writer start keeps the write layer
    p_single_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_start && cfg_single_layer) |=> (cur_w == $past(cur_w)));

    // R3: single-layer reader start follows the writer
    p_single_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_start && cfg_single_layer) |=> (rd_layer == $past(cur_w)));

    // R4: past the threshold the reader follows the writer
    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_start && !cfg_single_layer && beyond) |=> (rd_layer == $past(cur_w)));

    // R5: not past the threshold the reader takes the other layer
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_start && !cfg_single_layer && !beyond) |=> (rd_layer != $past(cur_w)));

    // R8: no reader start, no change of the read layer
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_frame_start |=> $stable(rd_layer));

    // R9: the displayed field mirrors the reader layer
    p_disp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_start |=> (status[DISP_LSB] == rd_layer));

endmodule

bind flb_layer_arbiter flb_layer_arbiter_chk #(.LINE_W(LINE_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_frame_start   (wr_frame_start),
    .rd_frame_start   (rd_frame_start),
    .wr_line          (wr_line),
    .wr_field         (wr_field),
    .cfg_threshold    (cfg_threshold),
    .cfg_single_layer (cfg_single_layer),
    .cfg_frame_mode   (cfg_frame_mode),
    .rd_layer         (rd_layer),
    .status           (status)
);

// File: tb/flb_layer_arbiter_tb.sv
// Bench: random and directed stimulus against a reference model held in
// bench variables and updated through bench functions.
module flb_layer_arbiter_tb_top;

    localparam int LINE_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_frame_start = 1'b0;
    logic              rd_frame_start = 1'b0;
    logic [LINE_W-1:0] wr_line = '0;
    logic              wr_field = 1'b0;
    logic [LINE_W:0]   cfg_threshold = '0;
    logic              cfg_single_layer = 1'b0;
    logic              cfg_frame_mode = 1'b0;
    logic              rd_layer;
    logic [15:0]       status;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state and the requirement behind the last change
    logic  m_cur = 1'b0;
    logic  m_prev = 1'b0;
    logic  m_rd = 1'b0;
    string rd_tag = "R1";
    string wr_tag = "R1";

    always #2.5 clk = ~clk;

    flb_layer_arbiter #(.LINE_W(LINE_W)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_frame_start   (wr_frame_start),
        .rd_frame_start   (rd_frame_start),
        .wr_line          (wr_line),
        .wr_field         (wr_field),
        .cfg_threshold    (cfg_threshold),
        .cfg_single_layer (cfg_single_layer),
        .cfg_frame_mode   (cfg_frame_mode),
        .rd_layer         (rd_layer),
        .status           (status)
    );

    // R4/R5/R6/R7: strict comparison of the writer position with the threshold
    function automatic logic past_thr(input logic [LINE_W-1:0] ln, input logic fld,
                                      input logic [LINE_W:0] thr, input logic frm);
        if (frm) return ({fld, ln} > thr);
        return (ln > thr[LINE_W-1:0]);
    endfunction

    // R9: expected status word
    function automatic logic [15:0] exp_status(input logic c, input logic p, input logic d);
        return {7'd0, d, 3'd0, p, 3'd0, c};
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rd_layer actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_status(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update for the inputs driven before the coming rising edge
    task automatic model_step();
        logic p;
        p = past_thr(wr_line, wr_field, cfg_threshold, cfg_frame_mode);
        if (rd_frame_start) begin
            if (cfg_single_layer) begin
                m_rd = m_cur; rd_tag = "R3";
            end else if (p) begin
                m_rd = m_cur;
                rd_tag = cfg_frame_mode ? "R7" : (cfg_threshold[LINE_W] ? "R6" : "R4");
            end else begin
                m_rd = ~m_cur;
                rd_tag = cfg_frame_mode ? "R7" : (cfg_threshold[LINE_W] ? "R6" : "R5");
            end
            if (wr_frame_start) rd_tag = "R10";
        end else begin
            rd_tag = "R8";
        end
        if (wr_frame_start) begin
            m_prev = m_cur;
            if (!cfg_single_layer) begin
                m_cur = ~m_cur; wr_tag = "R2";
            end else begin
                wr_tag = "R3";
            end
        end else begin
            wr_tag = "R9";
        end
    endtask

    // Check the outputs, drive one cycle of inputs, and advance the model
    task automatic step(input logic ws, input logic rs, input logic [LINE_W-1:0] ln,
                        input logic fld, input logic [LINE_W:0] thr,
                        input logic sgl, input logic frm);
        @(negedge clk);
        check_bit(rd_tag, rd_layer, m_rd);
        check_status(wr_tag, status, exp_status(m_cur, m_prev, m_rd));
        wr_frame_start   = ws;
        rd_frame_start   = rs;
        wr_line          = ln;
        wr_field         = fld;
        cfg_threshold    = thr;
        cfg_single_layer = sgl;
        cfg_frame_mode   = frm;
        model_step();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        check_bit("R1", rd_layer, 1'b0);
        check_status("R1", status, 16'h0000);

        // R2: writer toggles; R5: line equal to the threshold is not passed
        step(1, 0, 14'd100, 0, 15'd100, 0, 0);
        step(0, 1, 14'd100, 0, 15'd100, 0, 0);
        // R4: one line beyond the threshold follows the writer
        step(0, 1, 14'd101, 0, 15'd100, 0, 0);
        // R8: repeated reader starts show the same layer
        step(0, 1, 14'd200, 0, 15'd100, 0, 0);
        step(0, 0, 14'd0,   0, 15'd100, 0, 0);
        // R6: bit 14 ignored in field mode
        step(0, 1, 14'd50, 1, 15'h4000 | 15'd40, 0, 0);
        step(0, 1, 14'd30, 0, 15'h4000 | 15'd40, 0, 0);
        // R7: odd field with a low line ranks above an even-field threshold
        step(0, 1, 14'd1, 1, 15'd9000, 0, 1);
        // R7: even field with a high line stays below an odd-field threshold
        step(0, 1, 14'd9000, 0, 15'h4000 | 15'd1, 0, 1);
        // R10: simultaneous pulses use the write layer before the toggle
        step(1, 1, 14'd500, 0, 15'd10, 0, 0);
        step(1, 1, 14'd5, 0, 15'd10, 0, 0);
        // R3: single-layer mode holds the write layer and ignores the threshold
        step(1, 0, 14'd0, 0, 15'h7fff, 1, 1);
        step(0, 1, 14'd0, 0, 15'h7fff, 1, 1);
        step(1, 1, 14'd0, 0, 15'd0, 1, 0);

        // Random phase: line kept near the threshold line
        for (int i = 0; i < 4000; i++) begin
            logic [LINE_W:0]   thr;
            logic [LINE_W-1:0] ln;
            int                d;
            thr = 15'($urandom);
            d   = int'($urandom_range(0, 6)) - 3;
            ln  = thr[LINE_W-1:0] + 14'(d);
            step(($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0), ln,
                 1'($urandom), thr, ($urandom_range(0, 9) == 0), 1'($urandom));
        end
        step(0, 0, 14'd0, 0, 15'd0, 0, 0);
        @(negedge clk);
        check_bit(rd_tag, rd_layer, m_rd);
        check_status(wr_tag, status, exp_status(m_cur, m_prev, m_rd));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule